// File: doc/BRIEF.md
# Write Burst Data Scheduler

This block sits on the controller side of a double-data-rate SDRAM write path. It takes each accepted write command and, at the right clock, produces the enables that the physical layer needs. These are a one-clock strobe preamble, a pair of data-beat valids per clock with a beat index, CRC-beat markers, a postamble flag, and done pulses for the write-recovery and write-to-read timers. It computes no CRC, drives no pins and serialises no data. Command arbitration is left to the surrounding logic. The block only reports a command that arrives too soon after the previous one, and it schedules that command anyway.

Each command sets its write latency to additive latency plus CAS write latency at the moment it is issued. Its burst kind comes from a two-bit mode setting and the command's A12 bit. Each burst occupies a fixed window of `4 + CRC_CLK` clocks, two beats per clock. A chopped burst uses the same window with only its first four beats valid. When CRC is enabled, the CRC clock follows directly after the last valid data clock. Commands wait in a small queue that records each command's due time, burst kind and CRC setting.

Top module: `wr_burst_sched`

## Requirements
- R1: While reset is active and after it is released with no command, `dqs_pre`, `dqs_post`, `beat_dv`, `beat_crc`, `beat_idx`, `ccd_viol`, `wr_done` and `wtr_done` are all zero.
- R2: A command sampled in clock N makes its first data clock N + AL + CWL, with `beat_dv` = 2'b11 (bit 0 the earlier beat). `beat_idx` holds 2·k in window clock k and is 0 outside a window.
- R3: `dqs_pre` is high for exactly the one clock before a burst's first data clock.
- R4: Mode 2'b00 and 2'b11 select an 8-beat burst. Mode 2'b10 selects a 4-beat chop. Mode 2'b01 uses A12: A12 = 1 selects 8 beats and A12 = 0 selects a chop.
- R5: A chopped burst has data only in window clocks 0 and 1. The rest of its window carries no data.
- R6: With CRC enabled, the `CRC_CLK` clocks right after the last data clock have `beat_crc` = 2'b11. With CRC disabled, `beat_crc` stays 0. `beat_dv` and `beat_crc` are never both set.
- R7: `dqs_postamble` behaviour: `dqs_post` is high for one clock, the clock after a burst's last transferred beat (CRC beats count as transferred).
- R8: `wr_done` pulses once, T_WR clocks after the last transferred clock.
- R9: `wtr_done` pulses once, T_WTR clocks after the last transferred clock.
- R10: A newer burst that ends while a timer is still running reloads that timer, and the older count gives no pulse of its own. If the newer burst ends in the same clock as the older count expires, the older pulse still occurs and the timer restarts.
- R11: `ccd_viol` is high in the clock after a command that arrives fewer than TCCD clocks after the previous command. That command is still scheduled.
- R12: When windows overlap, the earlier burst is served to its end. The later burst then continues from its own schedule position, and its already elapsed clocks are lost.
- R13: Up to QDEPTH bursts may be outstanding. A command must not arrive while the queue is full.
- R14: Latency, mode and CRC settings are captured per command. Changing them later does not move a burst that is already queued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Write command accepted this clock |
| cmd_a12 | input | 1 | Per-command burst-length bit |
| cfg_bl_mode | input | 2 | Burst mode setting |
| cfg_crc_en | input | 1 | Append CRC beats |
| cfg_al | input | LAT_W | Additive latency |
| cfg_cwl | input | LAT_W | CAS write latency |
| dqs_pre | output | 1 | Strobe preamble enable |
| dqs_post | output | 1 | Strobe postamble enable |
| beat_dv | output | 2 | Data valid for the two beats of this clock |
| beat_crc | output | 2 | CRC-beat marker for the two beats |
| beat_idx | output | clog2(2·(4+CRC_CLK)) | Beat position of the earlier beat in the window |
| ccd_viol | output | 1 | Command spacing violation |
| wr_done | output | 1 | Write-recovery timer expired |
| wtr_done | output | 1 | Write-to-read timer expired |

## Verification
Two pairs of functions can meet in the same clock. In the first, an older burst's write-recovery expiry falls in the clock where a newer burst ends and reloads that timer. Two full bursts issued exactly T_WR clocks apart provoke this, and the check requires a pulse in that clock and a second pulse T_WR clocks later. In the second, an overlapping burst is handed over while its own window is already running. Two commands three clocks apart provoke this, and the check requires the second burst to resume at beat index 4 with the violation flag raised. A behavioural model in the bench predicts every output on every clock.

// File: rtl/wbs_pkg.sv
package wbs_pkg;

  typedef enum logic [1:0] {
    BLM_FULL  = 2'b00,
    BLM_OTF   = 2'b01,
    BLM_CHOP  = 2'b10,
    BLM_RSVD  = 2'b11
  } bl_mode_e;

  localparam int unsigned DATA_CLK_FULL = 4;
  localparam int unsigned DATA_CLK_CHOP = 2;

  function automatic logic pick_chop(input logic [1:0] mode, input logic a12);
    logic chop;
    case (bl_mode_e'(mode))
      BLM_OTF:  chop = ~a12;
      BLM_CHOP: chop = 1'b1;
      default:  chop = 1'b0;
    endcase
    return chop;
  endfunction

endpackage

// File: rtl/wbs_fifo.sv
module wbs_fifo #(
  parameter int unsigned W     = 10,
  parameter int unsigned DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         vld,
  output logic         full
);
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CNT_W = $clog2(DEPTH + 1);

  logic [W-1:0]     mem [DEPTH];
  logic [PTR_W-1:0] rptr_q, rptr_d, wptr_q, wptr_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             do_push, do_pop;

  assign vld     = (cnt_q != '0);
  assign full    = (cnt_q == CNT_W'(DEPTH));
  assign do_pop  = pop & vld;
  assign do_push = push & ~full;
  assign dout    = mem[rptr_q];

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_comb begin
    rptr_d = do_pop  ? bump(rptr_q) : rptr_q;
    wptr_d = do_push ? bump(wptr_q) : wptr_q;
    cnt_d  = cnt_q;
    if (do_push && !do_pop) cnt_d = cnt_q + 1'b1;
    else if (!do_push && do_pop) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rptr_q <= '0;
      wptr_q <= '0;
      cnt_q  <= '0;
    end else begin
      rptr_q <= rptr_d;
      wptr_q <= wptr_d;
      cnt_q  <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wptr_q] <= din;
  end

endmodule

// File: rtl/wbs_timer.sv
module wbs_timer #(
  parameter int unsigned CNT = 12
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  output logic done
);
  localparam int unsigned CW = $clog2(CNT + 1);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    if (load)              cnt_d = CW'(CNT);
    else if (cnt_q != '0)  cnt_d = cnt_q - 1'b1;
    else                   cnt_d = cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign done = (cnt_q == CW'(1));

endmodule

// File: rtl/wbs_spacing.sv
module wbs_spacing #(
  parameter int unsigned TCCD = 7
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cmd_valid,
  output logic viol
);
  localparam int unsigned GW = $clog2(TCCD + 1);

  logic [GW-1:0] gap_q, gap_d;
  logic          viol_q, viol_d;

  always_comb begin
    viol_d = cmd_valid && (gap_q < GW'(TCCD));
    if (cmd_valid)               gap_d = GW'(1);
    else if (gap_q < GW'(TCCD))  gap_d = gap_q + 1'b1;
    else                         gap_d = gap_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap_q  <= GW'(TCCD);
      viol_q <= 1'b0;
    end else begin
      gap_q  <= gap_d;
      viol_q <= viol_d;
    end
  end

  assign viol = viol_q;

endmodule

// File: rtl/wr_burst_sched.sv
module wr_burst_sched #(
  parameter int unsigned LAT_W   = 5,
  parameter int unsigned CRC_CLK = 1,
  parameter int unsigned QDEPTH  = 4,
  parameter int unsigned TCCD    = 7,
  parameter int unsigned T_WR    = 12,
  parameter int unsigned T_WTR   = 4
) (
  input  logic                                   clk,
  input  logic                                   rst_n,
  input  logic                                   cmd_valid,
  input  logic                                   cmd_a12,
  input  logic [1:0]                             cfg_bl_mode,
  input  logic                                   cfg_crc_en,
  input  logic [LAT_W-1:0]                       cfg_al,
  input  logic [LAT_W-1:0]                       cfg_cwl,
  output logic                                   dqs_pre,
  output logic                                   dqs_post,
  output logic [1:0]                             beat_dv,
  output logic [1:0]                             beat_crc,
  output logic [$clog2(2*(4+CRC_CLK))-1:0]       beat_idx,
  output logic                                   ccd_viol,
  output logic                                   wr_done,
  output logic                                   wtr_done
);
  import wbs_pkg::*;

  localparam int unsigned TS_W  = LAT_W + 3;
  localparam int unsigned SLOT  = DATA_CLK_FULL + CRC_CLK;
  localparam int unsigned IDX_W = $clog2(2 * SLOT);
  localparam int unsigned ENT_W = TS_W + 2;

  // time base
  logic [TS_W-1:0] now_q, now_d;

  // queue
  logic [ENT_W-1:0] push_ent, head_ent;
  logic             head_vld, q_full, pop;

  // head decode
  logic [TS_W-1:0] head_start, diff, data_clks, last_clk;
  logic            head_chop, head_crc, live, in_data, in_crc, end_beat;

  // postamble
  logic post_q, post_d;

  assign now_d    = now_q + 1'b1;
  assign push_ent = {cfg_crc_en, pick_chop(cfg_bl_mode, cmd_a12),
                     now_q + TS_W'(cfg_al) + TS_W'(cfg_cwl)};

  wbs_fifo #(.W(ENT_W), .DEPTH(QDEPTH)) u_q (
    .clk  (clk),
    .rst_n(rst_n),
    .push (cmd_valid),
    .din  (push_ent),
    .pop  (pop),
    .dout (head_ent),
    .vld  (head_vld),
    .full (q_full)
  );

  assign {head_crc, head_chop, head_start} = head_ent;

  always_comb begin
    diff      = now_q - head_start;
    data_clks = head_chop ? TS_W'(DATA_CLK_CHOP) : TS_W'(DATA_CLK_FULL);
    last_clk  = data_clks + (head_crc ? TS_W'(CRC_CLK) : '0) - 1'b1;
    live      = head_vld && (diff < TS_W'(SLOT));
    in_data   = live && (diff < data_clks);
    in_crc    = live && head_crc && (diff >= data_clks)
                && (diff < data_clks + TS_W'(CRC_CLK));
    end_beat  = live && (diff == last_clk);
    pop       = head_vld && !diff[TS_W-1] && (diff >= TS_W'(SLOT - 1));
    post_d    = end_beat;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      now_q  <= '0;
      post_q <= 1'b0;
    end else begin
      now_q  <= now_d;
      post_q <= post_d;
    end
  end

  assign dqs_pre  = head_vld && (diff == '1);
  assign dqs_post = post_q;
  assign beat_dv  = in_data ? 2'b11 : 2'b00;
  assign beat_crc = in_crc  ? 2'b11 : 2'b00;
  assign beat_idx = live ? {diff[IDX_W-2:0], 1'b0} : '0;

  wbs_spacing #(.TCCD(TCCD)) u_spc (
    .clk      (clk),
    .rst_n    (rst_n),
    .cmd_valid(cmd_valid),
    .viol     (ccd_viol)
  );

  localparam int unsigned NTMR = 2;
  logic [NTMR-1:0] tmr_done;

  for (genvar g = 0; g < NTMR; g++) begin : g_tmr
    wbs_timer #(.CNT(g == 0 ? T_WR : T_WTR)) u_tmr (
      .clk  (clk),
      .rst_n(rst_n),
      .load (end_beat),
      .done (tmr_done[g])
    );
  end

  assign wr_done  = tmr_done[0];
  assign wtr_done = tmr_done[1];

endmodule

// File: rtl/wr_burst_sched_chk.sv
module wr_burst_sched_chk #(
  parameter int unsigned TCCD  = 7,
  parameter int unsigned T_WR  = 12,
  parameter int unsigned T_WTR = 4
) (
  input logic       clk,
  input logic       rst_n,
  input logic       cmd_valid,
  input logic       dqs_pre,
  input logic       dqs_post,
  input logic [1:0] beat_dv,
  input logic [1:0] beat_crc,
  input logic       ccd_viol,
  input logic       wr_done,
  input logic       wtr_done,
  input logic       q_full
);
  localparam int unsigned GW = $clog2(TCCD + 1);
  logic [GW-1:0] since_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   since_q <= GW'(TCCD);
    else if (cmd_valid)           since_q <= GW'(1);
    else if (since_q < GW'(TCCD)) since_q <= since_q + 1'b1;
  end

  p_beat_pair_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (|beat_dv) |-> (beat_dv == 2'b11));

  p_pre_leads_data_r3: assert property (@(posedge clk) disable iff (!rst_n)
    dqs_pre |=> (beat_dv == 2'b11));

  p_dv_crc_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(|(beat_dv & beat_crc)));

  p_post_after_beat_r7: assert property (@(posedge clk) disable iff (!rst_n)
    dqs_post |-> ($past(|beat_dv) || $past(|beat_crc)));

  p_wr_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ((T_WR > 1) && wr_done) |=> !wr_done);

  p_wtr_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ((T_WTR > 1) && wtr_done) |=> !wtr_done);

  p_viol_set_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && (since_q < GW'(TCCD))) |=> ccd_viol);

  p_viol_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !(cmd_valid && (since_q < GW'(TCCD))) |=> !ccd_viol);

  p_no_overflow_r13: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> !q_full);

endmodule

bind wr_burst_sched wr_burst_sched_chk #(
  .TCCD (TCCD),
  .T_WR (T_WR),
  .T_WTR(T_WTR)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .cmd_valid(cmd_valid),
  .dqs_pre  (dqs_pre),
  .dqs_post (dqs_post),
  .beat_dv  (beat_dv),
  .beat_crc (beat_crc),
  .ccd_viol (ccd_viol),
  .wr_done  (wr_done),
  .wtr_done (wtr_done),
  .q_full   (q_full)
);

// File: tb/wr_burst_sched_tb.sv
module wr_burst_sched_tb;
  localparam int LAT_W = 5, CRC_CLK = 1, QDEPTH = 4, TCCD = 7, T_WR = 12, T_WTR = 4;
  localparam int SLOT = 4 + CRC_CLK;
  localparam int IDX_W = $clog2(2 * SLOT);
  localparam int NCYC = 300;

  logic clk, rst_n, cmd_valid, cmd_a12, cfg_crc_en;
  logic [1:0] cfg_bl_mode;
  logic [LAT_W-1:0] cfg_al, cfg_cwl;
  logic dqs_pre, dqs_post, ccd_viol, wr_done, wtr_done;
  logic [1:0] beat_dv, beat_crc;
  logic [IDX_W-1:0] beat_idx;

  int checks = 0, failures = 0;
  bit finished = 0;

  wr_burst_sched #(.LAT_W(LAT_W), .CRC_CLK(CRC_CLK), .QDEPTH(QDEPTH), .TCCD(TCCD),
                   .T_WR(T_WR), .T_WTR(T_WTR)) u_dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_a12(cmd_a12),
    .cfg_bl_mode(cfg_bl_mode), .cfg_crc_en(cfg_crc_en), .cfg_al(cfg_al), .cfg_cwl(cfg_cwl),
    .dqs_pre(dqs_pre), .dqs_post(dqs_post), .beat_dv(beat_dv), .beat_crc(beat_crc),
    .beat_idx(beat_idx), .ccd_viol(ccd_viol), .wr_done(wr_done), .wtr_done(wtr_done));

  initial clk = 1'b0;
  always #2 clk = ~clk;  // 250 MHz

  // behavioural reference state
  int q_start[$];
  bit q_chop[$];
  bit q_crc[$];
  int now_m = 0, gap_m = TCCD, wr_rem = 0, wtr_rem = 0;
  bit post_m = 0, viol_m = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s at t=%0t: actual=%0d expected=%0d", tag, $time, act, exp);
    end
  endtask

  // stimulus schedule
  task automatic stim(input int c);
    cmd_valid   = 1'b0;
    cmd_a12     = 1'b1;
    cfg_al      = '0;
    cfg_cwl     = LAT_W'(9);
    cfg_crc_en  = !(c >= 80 && c < 120);
    if (c < 40) cfg_bl_mode = 2'b01;
    else if (c < 47) cfg_bl_mode = 2'b00;
    else if (c < 80) cfg_bl_mode = 2'b10;
    else if (c >= 175 && c < 185) cfg_bl_mode = 2'b11;
    else cfg_bl_mode = 2'b01;
    case (c)
      5:   cmd_valid = 1'b1;                              // R2 full on-the-fly
      12:  begin cmd_valid = 1'b1; cmd_a12 = 1'b0; end    // R5 chop, R10 reload
      40:  begin cmd_valid = 1'b1; cmd_a12 = 1'b0; end    // R4 mode 00 full
      47:  cmd_valid = 1'b1;                              // R4 mode 10 chop
      80:  cmd_valid = 1'b1;                              // R6 crc off full
      100: begin cmd_valid = 1'b1; cmd_a12 = 1'b0; end    // R6 crc off chop
      130: cmd_valid = 1'b1;                              // R12 overlap
      133: cmd_valid = 1'b1;                              // R11 violation
      160: begin cmd_valid = 1'b1; cfg_al = LAT_W'(3); cfg_cwl = LAT_W'(5); end // R14
      180: begin cmd_valid = 1'b1; cmd_a12 = 1'b0; end    // R4 mode 11 full
      220: cmd_valid = 1'b1;                              // R10 coincidence
      232: cmd_valid = 1'b1;
      default: ;
    endcase
  endtask

  task automatic compare_and_step();
    bit hv, live, e_pre, e_end, e_pop;
    int d, dc, e_dv, e_crc, e_idx;
    hv = (q_start.size() > 0);
    d = hv ? now_m - q_start[0] : -100;
    dc = (hv && q_chop[0]) ? 2 : 4;
    live  = hv && d >= 0 && d < SLOT;
    e_pre = hv && d == -1;
    e_dv  = (live && d < dc) ? 3 : 0;
    e_crc = (live && q_crc[0] && d >= dc && d < dc + CRC_CLK) ? 3 : 0;
    e_idx = live ? 2 * d : 0;
    e_end = live && d == dc + (q_crc[0] ? CRC_CLK : 0) - 1;
    e_pop = hv && d >= SLOT - 1;

    chk(dqs_pre == e_pre, "R3 dqs_pre", dqs_pre, e_pre);
    chk(beat_dv == e_dv, "R2/R4/R5/R12 beat_dv", beat_dv, e_dv);
    chk(beat_idx == e_idx, "R2/R12 beat_idx", beat_idx, e_idx);
    chk(beat_crc == e_crc, "R6 beat_crc", beat_crc, e_crc);
    chk(dqs_post == post_m, "R7 dqs_post", dqs_post, post_m);
    chk(wr_done == (wr_rem == 1), "R8/R10 wr_done", wr_done, wr_rem == 1);
    chk(wtr_done == (wtr_rem == 1), "R9/R10 wtr_done", wtr_done, wtr_rem == 1);
    chk(ccd_viol == viol_m, "R11 ccd_viol", ccd_viol, viol_m);

    // advance the model as the coming edge will
    if (e_end) wr_rem = T_WR; else if (wr_rem > 0) wr_rem--;
    if (e_end) wtr_rem = T_WTR; else if (wtr_rem > 0) wtr_rem--;
    post_m = e_end;
    if (e_pop) begin
      void'(q_start.pop_front()); void'(q_chop.pop_front()); void'(q_crc.pop_front());
    end
    viol_m = cmd_valid && gap_m < TCCD;
    if (cmd_valid) begin
      q_start.push_back(now_m + int'(cfg_al) + int'(cfg_cwl));
      q_chop.push_back(cfg_bl_mode == 2'b10 || (cfg_bl_mode == 2'b01 && !cmd_a12));
      q_crc.push_back(cfg_crc_en);
      gap_m = 1;
    end else if (gap_m < TCCD) gap_m++;
    now_m++;
  endtask

  initial begin
    rst_n = 1'b0;
    stim(-1);
    repeat (4) @(negedge clk);
    // R1 reset state
    chk({dqs_pre, dqs_post, beat_dv, beat_crc, ccd_viol, wr_done, wtr_done} == '0 && beat_idx == '0,
        "R1 reset outputs", {dqs_pre, dqs_post, beat_dv, beat_crc}, 0);
    rst_n = 1'b1;
    for (int c = 0; c < NCYC; c++) begin
      if (c > 0) @(negedge clk);
      stim(c);
      if (c == 0) begin
        chk({dqs_pre, dqs_post, beat_dv, beat_crc, ccd_viol, wr_done, wtr_done} == '0,
            "R1 idle after reset", {dqs_pre, beat_dv}, 0);
      end
      compare_and_step();
    end
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(4 * 20000);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule